// File: doc/BRIEF.md
# Aligned Transfer Splitting Sequencer

This block sits on the master side of a serial memory-access link. It accepts one request at a time. A request carries a start byte address, a byte count and a direction. The block breaks the request into a series of frames for a separate serial shifter. For each frame it presents a command code, the frame's byte address and the frame's byte count. It holds these values until the shifter accepts the frame with a ready strobe. It then waits for a done strobe from the shifter before it works out the next frame.

Three frame sizes exist: a 2-byte frame, a 4-byte frame and a burst frame of any multiple of 8 bytes. Each choice depends on two things, the low three bits of the current address and the number of bytes still to move. Every frame then starts on its natural boundary, and a long transfer uses few frames. A request that breaks the alignment rules is refused with a one-cycle error pulse. The end of a legal request is marked by a one-cycle completion pulse.

Top module: `xfer_split_seq`

## Requirements
- R1: A 2-byte frame is chosen when the current address modulo 8 is 2 or 6, or when exactly 2 bytes remain. Its read code is 0.
- R2: If R1 does not apply, a 4-byte frame is chosen when the address modulo 8 is 4, or when 6 or fewer bytes remain. Its read code is 2.
- R3: In all other cases a burst frame is chosen, with read code 4. Its length is the remaining count rounded down to a multiple of 8, limited to BURST_MAX (240 by default).
- R4: frm_cmd is the read code for a read and the read code plus one for a write, in bits 2:0 with bits 7:3 zero.
- R5: The first frame's address is the request address. Each later frame's address is the request address plus the bytes issued by all earlier frames of that request.
- R6: A read with an odd address or an odd length is refused. req_error pulses high in the cycle after the request and no frame is presented.
- R7: A write with an odd address is refused as in R6. A write with an odd length is split as if its length were one larger.
- R8: A request of zero length is refused as in R6.
- R9: While frm_valid is high and frm_ready is low, frm_valid stays high and frm_cmd, frm_addr and frm_len stay unchanged.
- R10: After a frame is accepted, frm_valid stays low until frm_done is seen. The next frame then appears in the cycle after frm_done.
- R11: frm_done on the last frame causes a one-cycle xfer_complete pulse in the next cycle. In that same cycle req_ready is high again.
- R12: After reset, req_ready is high and frm_valid, req_error and xfer_complete are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken while req_ready is high |
| req_write | input | 1 | 1 for a write request, 0 for a read request |
| req_addr | input | AW | Start byte address |
| req_len | input | LW | Byte count |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_error | output | 1 | One-cycle pulse when a request is refused |
| frm_valid | output | 1 | A frame is being presented |
| frm_ready | input | 1 | Shifter accepts the presented frame |
| frm_cmd | output | 8 | Command code of the frame |
| frm_addr | output | AW | Byte address of the frame |
| frm_len | output | $clog2(BURST_MAX+1) | Byte count of the frame |
| frm_done | input | 1 | Shifter has finished the accepted frame |
| xfer_complete | output | 1 | One-cycle pulse after the final frame is done |

## Verification
The assertions are checked on every cycle. They cover the hold of a waiting frame, the legal frame lengths, natural alignment of every frame address, the match between each frame's length and its command code, the absence of frames during an error pulse, and that completion pulses are single-cycle and always follow a done strobe.

Some behaviour only the bench scenarios can show. This covers the exact sequence of frames for a given address and length, the contiguous addresses from frame to frame, padding of odd write lengths, and refusal of each kind of illegal request. The bench shows these by sweeping the low address bits and the lengths over both directions and comparing every frame against an arithmetic model.

// File: rtl/xs_pkg.sv
package xs_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_OFFER = 2'd1,
    ST_WAIT  = 2'd2
  } xs_state_t;

  // Read codes; the write code of each size is one higher.
  localparam logic [2:0] CODE_HALF  = 3'd0;
  localparam logic [2:0] CODE_WORD  = 3'd2;
  localparam logic [2:0] CODE_BURST = 3'd4;

  localparam int CMD_W = 8;

endpackage

// File: rtl/xs_req_check.sv
module xs_req_check #(
  parameter int AW  = 32,
  parameter int LW  = 16,
  localparam int TLW = LW + 1
) (
  input  logic           write_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [LW-1:0]  len_i,
  output logic           legal_o,
  output logic [TLW-1:0] total_o
);

  logic addr_odd;
  logic len_odd;
  logic len_zero;

  always_comb begin
    addr_odd = addr_i[0];
    len_odd  = len_i[0];
    len_zero = (len_i == '0);
    // Reads must be even in both address and length; writes only in address.
    legal_o  = !addr_odd && !len_zero && (write_i || !len_odd);
    // Odd writes carry one zero pad byte.
    total_o  = {1'b0, len_i} + {{(TLW-1){1'b0}}, (write_i & len_odd)};
  end

endmodule

// File: rtl/xs_cmd_sel.sv
module xs_cmd_sel
  import xs_pkg::*;
#(
  parameter int TLW       = 17,
  parameter int BURST_MAX = 240,
  localparam int FLW      = $clog2(BURST_MAX + 1)
) (
  input  logic [2:0]     align_i,
  input  logic [TLW-1:0] remain_i,
  input  logic           write_i,
  output logic [2:0]     code_o,
  output logic [FLW-1:0] len_o
);

  localparam logic [TLW-1:0] REM_TWO = TLW'(2);
  localparam logic [TLW-1:0] REM_SIX = TLW'(6);
  localparam logic [TLW-1:0] CAP     = TLW'(BURST_MAX);

  logic           pick_half;
  logic           pick_word;
  logic [TLW-1:0] rounded;
  logic [TLW-1:0] burst_len;
  logic [2:0]     base_code;

  always_comb begin
    pick_half = (align_i == 3'd2) || (align_i == 3'd6) || (remain_i == REM_TWO);
    pick_word = (align_i == 3'd4) || (remain_i <= REM_SIX);
    rounded   = {remain_i[TLW-1:3], 3'b000};
    burst_len = (rounded > CAP) ? CAP : rounded;
    if (pick_half) begin
      base_code = CODE_HALF;
      len_o     = FLW'(2);
    end else if (pick_word) begin
      base_code = CODE_WORD;
      len_o     = FLW'(4);
    end else begin
      base_code = CODE_BURST;
      len_o     = burst_len[FLW-1:0];
    end
    code_o = base_code | {2'b00, write_i};
  end

endmodule

// File: rtl/xfer_split_seq.sv
module xfer_split_seq
  import xs_pkg::*;
#(
  parameter int AW        = 32,
  parameter int LW        = 16,
  parameter int BURST_MAX = 240,
  localparam int FLW      = $clog2(BURST_MAX + 1),
  localparam int TLW      = LW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [AW-1:0]     req_addr,
  input  logic [LW-1:0]     req_len,
  output logic              req_ready,
  output logic              req_error,
  output logic              frm_valid,
  input  logic              frm_ready,
  output logic [CMD_W-1:0]  frm_cmd,
  output logic [AW-1:0]     frm_addr,
  output logic [FLW-1:0]    frm_len,
  input  logic              frm_done,
  output logic              xfer_complete
);

  xs_state_t      state_q, state_d;
  logic [AW-1:0]  addr_q, addr_d;
  logic [TLW-1:0] remain_q, remain_d;
  logic           write_q, write_d;
  logic           err_q, err_d;
  logic           cmp_q, cmp_d;
  logic           data_en;

  logic           req_legal;
  logic [TLW-1:0] req_total;
  logic [2:0]     sel_code;
  logic [FLW-1:0] sel_len;
  logic [TLW-1:0] sel_len_ext;
  logic           last_frame;

  xs_req_check #(.AW(AW), .LW(LW)) u_check (
    .write_i (req_write),
    .addr_i  (req_addr),
    .len_i   (req_len),
    .legal_o (req_legal),
    .total_o (req_total)
  );

  xs_cmd_sel #(.TLW(TLW), .BURST_MAX(BURST_MAX)) u_sel (
    .align_i  (addr_q[2:0]),
    .remain_i (remain_q),
    .write_i  (write_q),
    .code_o   (sel_code),
    .len_o    (sel_len)
  );

  assign sel_len_ext = {{(TLW-FLW){1'b0}}, sel_len};
  assign last_frame  = (remain_q == sel_len_ext);

  // Next-state logic
  always_comb begin
    state_d  = state_q;
    addr_d   = addr_q;
    remain_d = remain_q;
    write_d  = write_q;
    err_d    = 1'b0;
    cmp_d    = 1'b0;
    data_en  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          if (req_legal) begin
            data_en  = 1'b1;
            addr_d   = req_addr;
            remain_d = req_total;
            write_d  = req_write;
            state_d  = ST_OFFER;
          end else begin
            err_d = 1'b1;
          end
        end
      end
      ST_OFFER: begin
        if (frm_ready) state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (frm_done) begin
          data_en  = 1'b1;
          addr_d   = addr_q + {{(AW-FLW){1'b0}}, sel_len};
          remain_d = remain_q - sel_len_ext;
          if (last_frame) begin
            cmp_d   = 1'b1;
            state_d = ST_IDLE;
          end else begin
            state_d = ST_OFFER;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      err_q   <= 1'b0;
      cmp_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= err_d;
      cmp_q   <= cmp_d;
    end
  end

  // Data registers with explicit enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      remain_q <= '0;
      write_q  <= 1'b0;
    end else if (data_en) begin
      addr_q   <= addr_d;
      remain_q <= remain_d;
      write_q  <= write_d;
    end
  end

  assign req_ready     = (state_q == ST_IDLE);
  assign req_error     = err_q;
  assign frm_valid     = (state_q == ST_OFFER);
  assign frm_cmd       = {{(CMD_W-3){1'b0}}, sel_code};
  assign frm_addr      = addr_q;
  assign frm_len       = sel_len;
  assign xfer_complete = cmp_q;

endmodule

// File: rtl/xs_chk.sv
module xs_chk #(
  parameter int AW        = 32,
  parameter int BURST_MAX = 240,
  localparam int FLW      = $clog2(BURST_MAX + 1)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           frm_valid,
  input logic           frm_ready,
  input logic [7:0]     frm_cmd,
  input logic [AW-1:0]  frm_addr,
  input logic [FLW-1:0] frm_len,
  input logic           frm_done,
  input logic           req_error,
  input logic           xfer_complete
);

  // R9
  frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid && !frm_ready |=> frm_valid && $stable(frm_cmd) && $stable(frm_addr) && $stable(frm_len));

  // R3
  frame_len_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |-> (frm_len == FLW'(2)) || (frm_len == FLW'(4)) ||
                  (frm_len[2:0] == 3'd0 && frm_len != '0 && frm_len <= FLW'(BURST_MAX)));

  // R5
  frame_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |-> (frm_addr[0] == 1'b0) &&
                  (frm_len < FLW'(4) || frm_addr[1] == 1'b0) &&
                  (frm_len < FLW'(8) || frm_addr[2] == 1'b0));

  // R4
  cmd_matches_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |-> frm_cmd[7:3] == 5'd0 &&
                  ((frm_len == FLW'(2)) == (frm_cmd[2:1] == 2'd0)) &&
                  ((frm_len == FLW'(4)) == (frm_cmd[2:1] == 2'd1)));

  // R6
  no_frame_on_error_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_error |-> !frm_valid);

  // R11
  complete_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_complete |=> !xfer_complete);

  // R11
  complete_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_complete) |-> $past(frm_done));

endmodule

bind xfer_split_seq xs_chk #(.AW(AW), .BURST_MAX(BURST_MAX)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .frm_valid     (frm_valid),
  .frm_ready     (frm_ready),
  .frm_cmd       (frm_cmd),
  .frm_addr      (frm_addr),
  .frm_len       (frm_len),
  .frm_done      (frm_done),
  .req_error     (req_error),
  .xfer_complete (xfer_complete)
);

// File: tb/xfer_split_seq_tb.sv
module xfer_split_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int LW = 16;
  localparam int BMAX = 240;
  localparam int FLW = $clog2(BMAX + 1);

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           req_valid = 1'b0;
  logic           req_write = 1'b0;
  logic [AW-1:0]  req_addr = '0;
  logic [LW-1:0]  req_len = '0;
  logic           req_ready;
  logic           req_error;
  logic           frm_valid;
  logic           frm_ready = 1'b0;
  logic [7:0]     frm_cmd;
  logic [AW-1:0]  frm_addr;
  logic [FLW-1:0] frm_len;
  logic           frm_done = 1'b0;
  logic           xfer_complete;

  int n_checks = 0;
  int n_fails  = 0;
  int cycles   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xfer_split_seq #(.AW(AW), .LW(LW), .BURST_MAX(BMAX)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_len(req_len), .req_ready(req_ready),
    .req_error(req_error), .frm_valid(frm_valid), .frm_ready(frm_ready),
    .frm_cmd(frm_cmd), .frm_addr(frm_addr), .frm_len(frm_len),
    .frm_done(frm_done), .xfer_complete(xfer_complete)
  );

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  endtask

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000) begin
      n_fails++;
      $display("FAIL watchdog actual=%0d expected<190000", cycles);
      summary();
    end
  end

  // Arithmetic model of the frame rules (R1, R2, R3, R4)
  function automatic void model(input int align, input int remain, input bit wr,
                                output int code, output int flen);
    if (align == 2 || align == 6 || remain == 2) begin code = 0; flen = 2; end
    else if (align == 4 || remain <= 6) begin code = 2; flen = 4; end
    else begin
      code = 4;
      flen = (remain / 8) * 8;
      if (flen > BMAX) flen = BMAX;
    end
    code = code + (wr ? 1 : 0);
  endfunction

  task automatic run_req(input logic [AW-1:0] addr, input int len, input bit wr);
    int total;
    int issued;
    bit bad;
    total = (wr && (len % 2 == 1)) ? len + 1 : len;
    bad = addr[0] || (len == 0) || (!wr && (len % 2 == 1));
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = addr; req_len = LW'(len);
    @(negedge clk);
    req_valid = 1'b0;
    if (bad) begin
      // R6 R7 R8: refused, error pulse, no frame
      check(req_error == 1'b1, "R6/R8 error pulse", req_error, 1);
      check(frm_valid == 1'b0, "R6 no frame", frm_valid, 0);
      @(negedge clk);
      check(req_error == 1'b0 && req_ready && !frm_valid, "R8 error one cycle", req_error, 0);
      return;
    end
    check(req_error == 1'b0, "R7 legal request not refused", req_error, 0);
    issued = 0;
    for (int f = 0; issued < total; f++) begin
      int code, flen, hold;
      logic [AW-1:0] ea;
      ea = addr + AW'(issued);
      model(int'(ea[2:0]), total - issued, wr, code, flen);
      check(frm_valid == 1'b1, "R10 frame presented", frm_valid, 1);
      check(frm_cmd == 8'(code), "R4 command code", frm_cmd, code);
      check(frm_len == FLW'(flen), "R3 frame length", frm_len, flen);
      check(frm_addr == ea, "R5 frame address", frm_addr, ea);
      hold = f % 3;
      for (int h = 0; h < hold; h++) begin
        @(negedge clk);
        check(frm_valid && frm_cmd == 8'(code) && frm_len == FLW'(flen) && frm_addr == ea,
              "R9 held while not ready", frm_addr, ea);
      end
      frm_ready = 1'b1;
      @(negedge clk);
      frm_ready = 1'b0;
      check(frm_valid == 1'b0, "R10 no frame before done", frm_valid, 0);
      @(negedge clk);
      check(frm_valid == 1'b0 && !xfer_complete, "R10 waiting for done", frm_valid, 0);
      frm_done = 1'b1;
      @(negedge clk);
      frm_done = 1'b0;
      issued += flen;
      if (issued >= total) begin
        check(xfer_complete == 1'b1, "R11 complete pulse", xfer_complete, 1);
        check(req_ready == 1'b1, "R11 back to idle", req_ready, 1);
        check(issued == total, "R7 padded total", issued, total);
        @(negedge clk);
        check(xfer_complete == 1'b0, "R11 pulse one cycle", xfer_complete, 0);
      end else begin
        check(xfer_complete == 1'b0, "R11 no early complete", xfer_complete, 0);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    check(req_ready == 1'b1, "R12 ready in reset", req_ready, 1);
    check(!frm_valid && !req_error && !xfer_complete, "R12 outputs low in reset", frm_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !frm_valid && !req_error && !xfer_complete, "R12 after release", req_ready, 1);

    // Worked case: read 260 bytes at ...02 (R1 R2 R3)
    run_req(32'h6003_0002, 260, 1'b0);
    run_req(32'h6003_0002, 260, 1'b1);
    // Burst cap and large sizes
    for (int l = 236; l <= 262; l++) begin
      run_req(32'h6003_0000, l, 1'b0);
      run_req(32'h6003_0006, l, 1'b1);
    end
    // Sweep of alignments, lengths and directions (R1..R8)
    for (int a = 0; a < 10; a++)
      for (int l = 0; l <= 90; l++)
        for (int w = 0; w < 2; w++)
          run_req(32'h6003_0100 + 32'(a), l, w[0]);
    summary();
  end

endmodule